// File: doc/BRIEF.md
# DRAM Self-Test Address Sequencer with Alternating Complement

This block produces the address stream for a DRAM self-test engine. It keeps a composite address of a row field, a column field and a bank field. On each advance strobe it steps that address through a programmed window or through the whole address space. A 3-bit order code, sampled when a run starts, picks the nesting of the fields. The direction input, also sampled at start, picks counting up from the low bounds or down from the high bounds.

An optional ping-pong mode makes every second presented address the bitwise complement of the one before it, which keeps the address lines switching as much as possible. Column bit 0 is the exception and is never complemented. The complement covers the row, column and bank fields in every order and in both directions. It also covers the bank when the order holds the bank fixed, and it applies even when the complemented address falls outside the programmed window. The counters underneath step exactly as they would without the mode, so each counter value is presented once plainly and once complemented.

A test controller pulses start, then pulses advance once per access until done rises. Command sequencing, bank scheduling and data comparison belong to other blocks.

Top module: `bist_addr_gen`

## Requirements
- R1: After reset, valid_o, inv_o and done_o are 0, and row_o, col_o and bank_o are all zeros.
- R2: One cycle after start_i is pulsed, valid_o=1, inv_o=0 and done_o=0. The presented address is the low bounds when counting up (down_i=0) and the high bounds when counting down (down_i=1). In window addressing (full_i=0) the low bounds are the start_* fields and the high bounds are the end_* fields. In whole-space addressing (full_i=1) the low bounds are all zeros and the high bounds are all ones.
- R3: order_i picks the nesting. 0 = row fastest, then column. 1 = column fastest, then row. 2 = row and column step together on every count, each wrapping inside its own bounds, and the run ends when the row reaches its last value. 3 = column fastest, then bank, then row. Codes 4 to 7 behave as code 0. Each field wraps from its last value back to its first, and that wrap carries into the next outer field.
- R4: In orders 0, 1 and 2 the counted bank is fixed: start_bank_i in window addressing and 0 in whole-space addressing, in both directions.
- R5: With down_i=1 every counted field steps from its high bound toward its low bound, and wraps from the low bound back to the high bound.
- R6: With inv_en_i=1, every advance accepted while inv_o=0 produces inv_o=1. The address then presented is the previous address with every row, column and bank bit inverted except col_o bit 0. This holds for a fixed bank and for addresses outside the window, with no clipping.
- R7: With inv_en_i=1 the counter steps only on the advance that leaves the inverted phase. The plain addresses therefore form exactly the sequence that inv_en_i=0 gives.
- R8: The advance that leaves the last count value ends the run: valid_o=0 and done_o=1. The last count value is the high bounds when counting up and the low bounds when counting down. With inv_en_i=1 that advance is the one leaving its inverted phase. done_o then holds, and advance strobes have no effect, until the next start_i.
- R9: While advance_i=0, the presented address and inv_o stay unchanged.
- R10: order_i, full_i, down_i, inv_en_i and all bound inputs are used only in the start cycle. Changing them during a run does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; samples the configuration and bounds |
| advance_i | input | 1 | Move to the next access |
| order_i | input | 3 | Field nesting code |
| full_i | input | 1 | 1 = whole space, 0 = programmed window |
| down_i | input | 1 | 1 = count down |
| inv_en_i | input | 1 | Enable alternating complement |
| start_row_i | input | XW | Window low row |
| start_col_i | input | YW | Window low column |
| start_bank_i | input | ZW | Window low bank; fixed bank in orders 0 to 2 |
| end_row_i | input | XW | Window high row |
| end_col_i | input | YW | Window high column |
| end_bank_i | input | ZW | Window high bank |
| row_o | output | XW | Presented row address |
| col_o | output | YW | Presented column address |
| bank_o | output | ZW | Presented bank address |
| valid_o | output | 1 | A run is presenting addresses |
| inv_o | output | 1 | The presented address is the complemented form |
| done_o | output | 1 | Run finished |

## Verification
The address outputs are taken straight from the counter and phase flops through one XOR level. A wrong carry, wrap value or phase bit therefore shows on the ports in the same cycle as the faulty advance. It does not wait until the end of the run. A fault in the terminal-value decode shows as done_o rising early or late, or as an address outside the expected sequence in the cycle after the last count value. A configuration register that is captured wrongly corrupts the first presented address after start or the first wrap, and scrambling the inputs during a run exposes a register that keeps sampling after start.

// File: rtl/bist_addr_pkg.sv
package bist_addr_pkg;

   typedef enum logic [1:0] {
      SEQ_ROW_FAST  = 2'd0,
      SEQ_COL_FAST  = 2'd1,
      SEQ_DIAGONAL  = 2'd2,
      SEQ_ROW_BANK_COL = 2'd3
   } seq_t;

   function automatic seq_t decode_seq(input logic [2:0] code);
      case (code)
         3'd1:    return SEQ_COL_FAST;
         3'd2:    return SEQ_DIAGONAL;
         3'd3:    return SEQ_ROW_BANK_COL;
         default: return SEQ_ROW_FAST;
      endcase
   endfunction

   function automatic logic bank_is_fixed(input seq_t s);
      return s != SEQ_ROW_BANK_COL;
   endfunction

endpackage

// File: rtl/bist_field_ctr.sv
module bist_field_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         dn,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] val,
   output logic         at_term
);

   assign at_term = dn ? (val == lo) : (val == hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= '0;
      end else if (load) begin
         val <= load_val;
      end else if (step) begin
         if (at_term)
            val <= dn ? hi : lo;
         else
            val <= dn ? (val - W'(1)) : (val + W'(1));
      end
   end

endmodule

// File: rtl/bist_phase_ctrl.sv
module bist_phase_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic adv,
   input  logic dai,
   input  logic last,
   output logic cnt_step,
   output logic phase,
   output logic valid,
   output logic done
);

   logic accept;
   logic leave;

   assign accept   = valid & adv & ~start;
   assign leave    = accept & (~dai | phase);
   assign cnt_step = leave & ~last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
         valid <= 1'b0;
         done  <= 1'b0;
      end else if (start) begin
         phase <= 1'b0;
         valid <= 1'b1;
         done  <= 1'b0;
      end else if (accept) begin
         if (dai && !phase) begin
            phase <= 1'b1;
         end else begin
            phase <= 1'b0;
            if (last) begin
               valid <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bist_addr_gen.sv
module bist_addr_gen
   import bist_addr_pkg::*;
#(
   parameter int XW = 4,
   parameter int YW = 4,
   parameter int ZW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          advance_i,
   input  logic [2:0]    order_i,
   input  logic          full_i,
   input  logic          down_i,
   input  logic          inv_en_i,
   input  logic [XW-1:0] start_row_i,
   input  logic [YW-1:0] start_col_i,
   input  logic [ZW-1:0] start_bank_i,
   input  logic [XW-1:0] end_row_i,
   input  logic [YW-1:0] end_col_i,
   input  logic [ZW-1:0] end_bank_i,
   output logic [XW-1:0] row_o,
   output logic [YW-1:0] col_o,
   output logic [ZW-1:0] bank_o,
   output logic          valid_o,
   output logic          inv_o,
   output logic          done_o
);

   if (XW < 1) begin : g_bad_xw
      $error("bist_addr_gen: XW must be at least 1");
   end
   if (YW < 1) begin : g_bad_yw
      $error("bist_addr_gen: YW must be at least 1");
   end
   if (ZW < 1) begin : g_bad_zw
      $error("bist_addr_gen: ZW must be at least 1");
   end

   localparam int AW = XW + YW + ZW;

   // Column inversion mask keeps bit 0 untouched.
   logic [YW-1:0] col_mask;
   if (YW > 1) begin : g_mask_wide
      assign col_mask = {{(YW-1){1'b1}}, 1'b0};
   end else begin : g_mask_one
      assign col_mask = '0;
   end

   // Bounds as they will apply to the run being started.
   seq_t          seq_n;
   logic [XW-1:0] lo_x_n, hi_x_n, ld_x;
   logic [YW-1:0] lo_y_n, hi_y_n, ld_y;
   logic [ZW-1:0] lo_z_n, hi_z_n, ld_z;

   always_comb begin
      seq_n  = decode_seq(order_i);
      lo_x_n = full_i ? '0 : start_row_i;
      hi_x_n = full_i ? '1 : end_row_i;
      lo_y_n = full_i ? '0 : start_col_i;
      hi_y_n = full_i ? '1 : end_col_i;
      lo_z_n = full_i ? '0 : start_bank_i;
      hi_z_n = full_i ? '1 : end_bank_i;
      ld_x   = down_i ? hi_x_n : lo_x_n;
      ld_y   = down_i ? hi_y_n : lo_y_n;
      ld_z   = (bank_is_fixed(seq_n) || !down_i) ? lo_z_n : hi_z_n;
   end

   // Run configuration, captured once per start.
   seq_t          seq_q;
   logic          dn_q, dai_q;
   logic [XW-1:0] lo_x_q, hi_x_q;
   logic [YW-1:0] lo_y_q, hi_y_q;
   logic [ZW-1:0] lo_z_q, hi_z_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= SEQ_ROW_FAST;
         dn_q   <= 1'b0;
         dai_q  <= 1'b0;
         lo_x_q <= '0;
         hi_x_q <= '0;
         lo_y_q <= '0;
         hi_y_q <= '0;
         lo_z_q <= '0;
         hi_z_q <= '0;
      end else if (start_i) begin
         seq_q  <= seq_n;
         dn_q   <= down_i;
         dai_q  <= inv_en_i;
         lo_x_q <= lo_x_n;
         hi_x_q <= hi_x_n;
         lo_y_q <= lo_y_n;
         hi_y_q <= hi_y_n;
         lo_z_q <= lo_z_n;
         hi_z_q <= hi_z_n;
      end
   end

   // Carry chain per nesting order.
   logic          step, phase, last;
   logic          en_x, en_y, en_z;
   logic          t_x, t_y, t_z;
   logic [XW-1:0] cnt_x;
   logic [YW-1:0] cnt_y;
   logic [ZW-1:0] cnt_z;

   always_comb begin
      en_x = 1'b0;
      en_y = 1'b0;
      en_z = 1'b0;
      last = 1'b0;
      case (seq_q)
         SEQ_ROW_FAST: begin
            en_x = step;
            en_y = step & t_x;
            last = t_x & t_y;
         end
         SEQ_COL_FAST: begin
            en_y = step;
            en_x = step & t_y;
            last = t_x & t_y;
         end
         SEQ_DIAGONAL: begin
            en_x = step;
            en_y = step;
            last = t_x;
         end
         default: begin
            en_y = step;
            en_z = step & t_y;
            en_x = step & t_y & t_z;
            last = t_x & t_y & t_z;
         end
      endcase
   end

   bist_field_ctr #(.W(XW)) u_row (
      .clk(clk), .rst_n(rst_n), .load(start_i), .load_val(ld_x),
      .step(en_x), .dn(dn_q), .lo(lo_x_q), .hi(hi_x_q),
      .val(cnt_x), .at_term(t_x)
   );

   bist_field_ctr #(.W(YW)) u_col (
      .clk(clk), .rst_n(rst_n), .load(start_i), .load_val(ld_y),
      .step(en_y), .dn(dn_q), .lo(lo_y_q), .hi(hi_y_q),
      .val(cnt_y), .at_term(t_y)
   );

   bist_field_ctr #(.W(ZW)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(start_i), .load_val(ld_z),
      .step(en_z), .dn(dn_q), .lo(lo_z_q), .hi(hi_z_q),
      .val(cnt_z), .at_term(t_z)
   );

   bist_phase_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start_i), .adv(advance_i),
      .dai(dai_q), .last(last), .cnt_step(step), .phase(phase),
      .valid(valid_o), .done(done_o)
   );

   // Presented address: counter value, complemented in the odd phase.
   logic [AW-1:0] addr_flat;
   assign addr_flat = {cnt_x ^ {XW{phase}},
                       cnt_y ^ (phase ? col_mask : '0),
                       cnt_z ^ {ZW{phase}}};
   assign row_o  = addr_flat[AW-1 -: XW];
   assign col_o  = addr_flat[ZW +: YW];
   assign bank_o = addr_flat[ZW-1:0];
   assign inv_o  = phase;

endmodule

// File: rtl/bist_addr_gen_chk.sv
module bist_addr_gen_chk #(
   parameter int XW = 4,
   parameter int YW = 4,
   parameter int ZW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          advance_i,
   input logic [XW-1:0] row_o,
   input logic [YW-1:0] col_o,
   input logic [ZW-1:0] bank_o,
   input logic          valid_o,
   input logic          inv_o,
   input logic          done_o
);

   localparam logic [YW-1:0] CFLIP = ~YW'(1);

   // R6: the complemented access mirrors the one before it
   p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(inv_o) && valid_o) |->
         (row_o == ~$past(row_o)) && ((col_o ^ $past(col_o)) == CFLIP) &&
         (bank_o == ~$past(bank_o)));

   // R6: the inverted phase lasts one accepted advance
   p_phase_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && inv_o && advance_i && !start_i) |=> !inv_o);

   // R2: a run opens with a plain access
   p_first_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && !inv_o && !done_o));

   // R9: nothing moves without an advance
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !advance_i && !start_i) |=>
         ($stable(row_o) && $stable(col_o) && $stable(bank_o) && $stable(inv_o)));

   // R8: finished state holds until restarted
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && !valid_o));

   // R8: done and valid never overlap
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && valid_o));

endmodule

bind bist_addr_gen bist_addr_gen_chk #(.XW(XW), .YW(YW), .ZW(ZW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
   .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
   .valid_o(valid_o), .inv_o(inv_o), .done_o(done_o)
);

// File: tb/tb_bist_addr_gen.sv
module tb_bist_addr_gen;

   localparam int XW = 4;
   localparam int YW = 4;
   localparam int ZW = 2;
   localparam int PW = 3 + XW + YW + ZW;
   localparam logic [YW-1:0] CM = ~YW'(1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, advance_i = 1'b0;
   logic [2:0]    order_i = '0;
   logic          full_i = 1'b0, down_i = 1'b0, inv_en_i = 1'b0;
   logic [XW-1:0] start_row_i = '0, end_row_i = '0;
   logic [YW-1:0] start_col_i = '0, end_col_i = '0;
   logic [ZW-1:0] start_bank_i = '0, end_bank_i = '0;
   logic [XW-1:0] row_o;
   logic [YW-1:0] col_o;
   logic [ZW-1:0] bank_o;
   logic          valid_o, inv_o, done_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   bist_addr_gen #(.XW(XW), .YW(YW), .ZW(ZW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
      .order_i(order_i), .full_i(full_i), .down_i(down_i), .inv_en_i(inv_en_i),
      .start_row_i(start_row_i), .start_col_i(start_col_i), .start_bank_i(start_bank_i),
      .end_row_i(end_row_i), .end_col_i(end_col_i), .end_bank_i(end_bank_i),
      .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
      .valid_o(valid_o), .inv_o(inv_o), .done_o(done_o)
   );

   task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] obs();
      return {valid_o, inv_o, done_o, row_o, col_o, bank_o};
   endfunction

   task automatic scramble();
      order_i = ~order_i; full_i = ~full_i; down_i = ~down_i; inv_en_i = ~inv_en_i;
      start_row_i = ~start_row_i; end_row_i = ~end_row_i;
      start_col_i = ~start_col_i; end_col_i = ~end_col_i;
      start_bank_i = ~start_bank_i; end_bank_i = ~end_bank_i;
   endtask

   // Called at a falling edge; advance_i is held high through the access.
   task automatic emit(input logic [XW-1:0] x, input logic [YW-1:0] y, input logic [ZW-1:0] z,
                       input bit dai, input bit stall, input string tag);
      chk({tag, " plain"}, obs(), {3'b100, x, y, z});
      if (stall) begin
         advance_i = 1'b0;
         scramble();
         @(negedge clk);
         chk({tag, " R9 R10 hold"}, obs(), {3'b100, x, y, z});
      end
      advance_i = 1'b1;
      @(negedge clk);
      if (dai) begin
         chk({tag, " R6 complement"}, obs(), {3'b110, ~x, y ^ CM, ~z});
         @(negedge clk);
      end
   endtask

   task automatic run(input int mode, input bit full, input bit dn, input bit dai, input bit stall,
                      input logic [XW-1:0] sx, input logic [XW-1:0] ex,
                      input logic [YW-1:0] sy, input logic [YW-1:0] ey,
                      input logic [ZW-1:0] sz, input logic [ZW-1:0] ez, input string tag);
      logic [XW-1:0] lx, hx, x;
      logic [YW-1:0] ly, hy, y;
      logic [ZW-1:0] lz, hz, z;
      int nx, ny, nz, em;
      lx = full ? '0 : sx; hx = full ? '1 : ex;
      ly = full ? '0 : sy; hy = full ? '1 : ey;
      lz = full ? '0 : sz; hz = full ? '1 : ez;
      nx = int'(hx) - int'(lx) + 1;
      ny = int'(hy) - int'(ly) + 1;
      nz = int'(hz) - int'(lz) + 1;
      em = (mode > 3) ? 0 : mode;
      order_i = 3'(mode); full_i = full; down_i = dn; inv_en_i = dai;
      start_row_i = sx; end_row_i = ex; start_col_i = sy; end_col_i = ey;
      start_bank_i = sz; end_bank_i = ez;
      advance_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (em == 0) begin
         for (int b = 0; b < ny; b++)
            for (int a = 0; a < nx; a++) begin
               x = dn ? hx - XW'(a) : lx + XW'(a);
               y = dn ? hy - YW'(b) : ly + YW'(b);
               emit(x, y, lz, dai, stall, tag);
            end
      end else if (em == 1) begin
         for (int a = 0; a < nx; a++)
            for (int b = 0; b < ny; b++) begin
               x = dn ? hx - XW'(a) : lx + XW'(a);
               y = dn ? hy - YW'(b) : ly + YW'(b);
               emit(x, y, lz, dai, stall, tag);
            end
      end else if (em == 2) begin
         for (int a = 0; a < nx; a++) begin
            x = dn ? hx - XW'(a) : lx + XW'(a);
            y = dn ? hy - YW'(a % ny) : ly + YW'(a % ny);
            emit(x, y, lz, dai, stall, tag);
         end
      end else begin
         for (int a = 0; a < nx; a++)
            for (int c = 0; c < nz; c++)
               for (int b = 0; b < ny; b++) begin
                  x = dn ? hx - XW'(a) : lx + XW'(a);
                  y = dn ? hy - YW'(b) : ly + YW'(b);
                  z = dn ? hz - ZW'(c) : lz + ZW'(c);
                  emit(x, y, z, dai, stall, tag);
               end
      end
      advance_i = 1'b0;
      chk({tag, " R8 done"}, {valid_o, inv_o, done_o, {(PW-3){1'b0}}}, {3'b001, {(PW-3){1'b0}}});
   endtask

   task automatic t_reset();
      chk("R1 reset state", obs(), '0);
   endtask

   task automatic t_done_hold();
      advance_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R8 done holds under advance", {valid_o, inv_o, done_o, {(PW-3){1'b0}}},
             {3'b001, {(PW-3){1'b0}}});
      end
      advance_i = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run(0, 0, 0, 0, 0, 4'd2, 4'd4, 4'd5, 4'd6, 2'd2, 2'd0, "R2 R3 R4 row-fast up window");
      run(1, 1, 1, 0, 0, 4'd3, 4'd1, 4'd7, 4'd2, 2'd3, 2'd1, "R2 R4 R5 col-fast down full");
      run(2, 0, 0, 1, 1, 4'd1, 4'd5, 4'd3, 4'd4, 2'd1, 2'd3, "R3 R6 R7 R9 R10 diagonal");
      run(3, 0, 1, 1, 0, 4'd6, 4'd7, 4'd9, 4'd11, 2'd1, 2'd2, "R3 R5 R6 row-bank-col down");
      run(0, 0, 0, 1, 0, 4'd0, 4'd1, 4'd0, 4'd1, 2'd1, 2'd2, "R4 R6 fixed bank flips");
      run(6, 0, 0, 0, 0, 4'd0, 4'd2, 4'd0, 4'd1, 2'd0, 2'd0, "R3 reserved code aliases");
      t_done_hold();
      run(3, 1, 0, 0, 0, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 2'd0, "R2 R3 R8 restart full");
      run(1, 0, 1, 1, 1, 4'd8, 4'd9, 4'd12, 4'd14, 2'd2, 2'd2, "R5 R6 R7 R10 col-fast down");
      summary();
   end

endmodule